// File: doc/BRIEF.md
# Programmable Interval Counter Channel

A single 16-bit counting channel for an interval timer. Software-side logic (bus decode, readback latching) sits in a neighbouring block. That block presents a one-cycle load strobe carrying a count, a mode and a decimal flag. Counting advances once for each cycle in which `tick_en` is high. A gate input either pauses counting or retriggers it, depending on the mode. The channel produces an output waveform and a live count value. A full timer uses three of these channels.

Six modes shape the output:
- Mode 0 raises the output at terminal count and holds it there.
- Mode 1 is a retriggerable one-shot.
- Mode 2 is a rate generator with a one-tick pulse on each period.
- Mode 3 is a square wave.
- Modes 4 and 5 each give a single strobe, started by software (4) or by the gate (5).

A loaded count of zero means a 65536-tick period. The decimal flag is only stored; counting is always binary.

The behaviour is defined in terms of ticks elapsed since the last load or restart, here called E. N is the effective loaded count, 1 to 65536. Count values are read modulo 65536.

Top module: `tmr_channel`

## Requirements
- R1: While `rst` is high and afterwards until the first load, `mode_valid`, `out_wave` and `count_val` are 0, and ticks and gate changes have no effect on them.
- R2: A load strobe captures N (0 means 65536), the folded mode and the decimal flag, and clears E. In the cycle after a load, `count_val` equals `load_count` and `cfg_bcd` equals `load_bcd`. A load takes priority over a tick in the same cycle.
- R3: A `load_mode` of 6 reads back on `cfg_mode` as 2, and 7 reads back as 3. Values 0 to 5 are kept unchanged.
- R4: In modes 0 and 4, E advances on a tick only while `gate_in` is high. In modes 1, 2, 3 and 5, E advances on every tick, and a rising edge of `gate_in` (high now, low in the previous cycle) resets E to 0 instead of advancing.
- R5: Mode 0: `out_wave` is 1 exactly when E >= N. Once high, it stays high until the next load.
- R6: Mode 1: `out_wave` is 1 exactly when E < N.
- R7: Mode 2: `out_wave` is 1 when E mod N = 0 and E != 0. `count_val` = N - (E mod N).
- R8: Mode 3: `out_wave` is 1 when E mod N < (N+1)/2 (integer division). `count_val` = N - (2E mod N), so the count steps down by two per tick.
- R9: Modes 4 and 5: `out_wave` is 1 only when E = N, which is a single-tick strobe.
- R10: In modes 0, 1, 4 and 5, `count_val` = (N - E) mod 65536, so it wraps past zero to 0xFFFF. In modes 2 and 3 it reloads from N as given in R7 and R8.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Counting clock enable, one tick per high cycle |
| gate_in | input | 1 | Gate: enable in modes 0/4, retrigger in modes 1/2/3/5 |
| load_stb | input | 1 | One-cycle strobe that loads count, mode and decimal flag |
| load_mode | input | 3 | Mode field of the load (6 and 7 fold to 2 and 3) |
| load_bcd | input | 1 | Decimal flag, stored only |
| load_count | input | 16 | Count value, 0 meaning 65536 |
| out_wave | output | 1 | Registered output waveform |
| count_val | output | 16 | Registered live count |
| cfg_mode | output | 3 | Folded mode currently in force |
| cfg_bcd | output | 1 | Stored decimal flag |
| mode_valid | output | 1 | Set by the first load after reset |

## Verification
The bench targets several corner cases, and each has a visible failure signature:
- **Zero load.** A design that takes zero literally would show a count of 0 that stays put, or that fires at once, instead of wrapping to 0xFFFF.
- **Odd square-wave periods (N = 5).** A wrong half-period split lengthens or shortens the high phase by a tick.
- **N = 1 in the rate generator.** This catches a pulse that never appears.
- **Gate behaviour.** Gate-low stalls in mode 0 and gate rising edges in modes 1, 3 and 5 expose a design that confuses "pause" with "restart": the count either keeps running or fails to jump back to N.
- **Strobe modes.** A strobe that lingers for more than one tick shows up directly.
- **Mode-field folding.** A mode 6 or 7 that is not folded would leave the output dead.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  typedef enum logic [2:0] {
    MD_TERM    = 3'd0,
    MD_ONESHOT = 3'd1,
    MD_RATE    = 3'd2,
    MD_SQUARE  = 3'd3,
    MD_SWSTB   = 3'd4,
    MD_HWSTB   = 3'd5
  } tmr_mode_e;

  // 6 and 7 collapse onto the periodic modes 2 and 3
  function automatic tmr_mode_e fold_mode(input logic [2:0] raw);
    if (raw[2] && raw[1]) return tmr_mode_e'({1'b0, raw[1:0]});
    return tmr_mode_e'(raw);
  endfunction

  // modes whose gate edge restarts the count instead of pausing it
  function automatic logic gate_retrigs(input tmr_mode_e m);
    return !(m == MD_TERM || m == MD_SWSTB);
  endfunction

endpackage

// File: rtl/tmr_ctl.sv
module tmr_ctl
  import tmr_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick_en,
  input  logic          gate_in,
  input  logic          load_stb,
  input  logic [2:0]    load_mode,
  input  logic          load_bcd,
  input  logic [CW-1:0] load_count,
  output tmr_mode_e     mode_q,
  output tmr_mode_e     mode_d,
  output logic          valid_q,
  output logic          valid_d,
  output logic          bcd_q,
  output logic [CW:0]   n_d,
  output logic          start,
  output logic          adv
);

  logic [CW:0] n_q;
  logic [CW:0] full_n;
  logic        gate_q;
  logic        gate_rise;

  assign gate_rise = gate_in & ~gate_q;
  assign full_n    = (load_count == '0) ? {1'b1, {CW{1'b0}}} : {1'b0, load_count};

  always_comb begin
    mode_d  = mode_q;
    valid_d = valid_q;
    n_d     = n_q;
    start   = 1'b0;
    adv     = 1'b0;
    if (load_stb) begin
      mode_d  = fold_mode(load_mode);
      valid_d = 1'b1;
      n_d     = full_n;
      start   = 1'b1;
    end else if (valid_q) begin
      start = gate_retrigs(mode_q) && gate_rise;
      adv   = tick_en && !start && (gate_retrigs(mode_q) || gate_in);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q  <= MD_TERM;
      valid_q <= 1'b0;
      n_q     <= '0;
      gate_q  <= 1'b0;
      bcd_q   <= 1'b0;
    end else begin
      mode_q  <= mode_d;
      valid_q <= valid_d;
      n_q     <= n_d;
      gate_q  <= gate_in;
      if (load_stb) bcd_q <= load_bcd;
    end
  end

endmodule

// File: rtl/tmr_elapsed.sv
module tmr_elapsed #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          adv,
  input  logic [CW:0]   n_d,
  output logic [CW:0]   el_d,
  output logic [CW-1:0] dn_d
);

  localparam int NW = CW + 1;
  localparam logic [NW-1:0] EL_ONE = NW'(1);
  localparam logic [CW-1:0] DN_ONE = CW'(1);

  logic [NW-1:0] el_q;
  logic [CW-1:0] dn_q;

  // el saturates one past N, enough to tell E<N, E==N and E>N apart
  always_comb begin
    el_d = el_q;
    dn_d = dn_q;
    if (start) begin
      el_d = '0;
      dn_d = n_d[CW-1:0];
    end else if (adv) begin
      dn_d = dn_q - DN_ONE;
      if (el_q <= n_d) el_d = el_q + EL_ONE;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      el_q <= '0;
      dn_q <= '0;
    end else begin
      el_q <= el_d;
      dn_q <= dn_d;
    end
  end

endmodule

// File: rtl/tmr_phase.sv
module tmr_phase #(
  parameter int CW = 16
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        start,
  input  logic        adv,
  input  logic [CW:0] n_d,
  output logic [CW:0] ph_d,
  output logic [CW:0] ph2_d,
  output logic        run_d
);

  localparam int NW = CW + 1;
  localparam logic [NW-1:0] P_ONE = NW'(1);
  localparam logic [NW:0]   P_TWO = (NW+1)'(2);

  logic [NW-1:0] ph_q, ph2_q;
  logic          run_q;
  logic [NW-1:0] ph_inc;
  logic [NW:0]   s2, n_ext;

  assign ph_inc = ph_q + P_ONE;
  assign s2     = {1'b0, ph2_q} + P_TWO;
  assign n_ext  = {1'b0, n_d};

  // ph tracks E mod N, ph2 tracks 2E mod N
  always_comb begin
    ph_d  = ph_q;
    ph2_d = ph2_q;
    run_d = run_q;
    if (start) begin
      ph_d  = '0;
      ph2_d = '0;
      run_d = 1'b0;
    end else if (adv) begin
      run_d = 1'b1;
      ph_d  = (ph_inc == n_d) ? '0 : ph_inc;
      if (n_d == P_ONE)      ph2_d = '0;
      else if (s2 >= n_ext)  ph2_d = NW'(s2 - n_ext);
      else                   ph2_d = NW'(s2);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q  <= '0;
      ph2_q <= '0;
      run_q <= 1'b0;
    end else begin
      ph_q  <= ph_d;
      ph2_q <= ph2_d;
      run_q <= run_d;
    end
  end

endmodule

// File: rtl/tmr_outsel.sv
module tmr_outsel
  import tmr_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  tmr_mode_e     mode_d,
  input  logic          valid_d,
  input  logic [CW:0]   n_d,
  input  logic [CW:0]   el_d,
  input  logic [CW-1:0] dn_d,
  input  logic [CW:0]   ph_d,
  input  logic [CW:0]   ph2_d,
  input  logic          run_d,
  output logic          out_wave,
  output logic [CW-1:0] count_val
);

  localparam int NW = CW + 1;
  localparam logic [NW:0] H_ONE = (NW+1)'(1);

  logic [NW:0]   half;
  logic          w_nx;
  logic [CW-1:0] c_nx;

  assign half = ({1'b0, n_d} + H_ONE) >> 1;

  always_comb begin
    unique case (mode_d)
      MD_TERM:    begin w_nx = (el_d >= n_d);              c_nx = dn_d; end
      MD_ONESHOT: begin w_nx = (el_d <  n_d);              c_nx = dn_d; end
      MD_RATE:    begin w_nx = (ph_d == '0) && run_d;      c_nx = CW'(n_d - ph_d); end
      MD_SQUARE:  begin w_nx = ({1'b0, ph_d} < half);      c_nx = CW'(n_d - ph2_d); end
      default:    begin w_nx = (el_d == n_d);              c_nx = dn_d; end
    endcase
    if (!valid_d) begin
      w_nx = 1'b0;
      c_nx = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_wave  <= 1'b0;
      count_val <= '0;
    end else begin
      out_wave  <= w_nx;
      count_val <= c_nx;
    end
  end

endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick_en,
  input  logic          gate_in,
  input  logic          load_stb,
  input  logic [2:0]    load_mode,
  input  logic          load_bcd,
  input  logic [CW-1:0] load_count,
  output logic          out_wave,
  output logic [CW-1:0] count_val,
  output logic [2:0]    cfg_mode,
  output logic          cfg_bcd,
  output logic          mode_valid
);

  tmr_mode_e     mode_q, mode_d;
  logic          valid_q, valid_d, bcd_q;
  logic [CW:0]   n_d, el_d, ph_d, ph2_d;
  logic [CW-1:0] dn_d;
  logic          start, adv, run_d;

  tmr_ctl #(.CW(CW)) u_ctl (
    .clk(clk), .rst(rst), .tick_en(tick_en), .gate_in(gate_in),
    .load_stb(load_stb), .load_mode(load_mode), .load_bcd(load_bcd),
    .load_count(load_count), .mode_q(mode_q), .mode_d(mode_d),
    .valid_q(valid_q), .valid_d(valid_d), .bcd_q(bcd_q), .n_d(n_d),
    .start(start), .adv(adv)
  );

  tmr_elapsed #(.CW(CW)) u_el (
    .clk(clk), .rst(rst), .start(start), .adv(adv), .n_d(n_d),
    .el_d(el_d), .dn_d(dn_d)
  );

  tmr_phase #(.CW(CW)) u_ph (
    .clk(clk), .rst(rst), .start(start), .adv(adv), .n_d(n_d),
    .ph_d(ph_d), .ph2_d(ph2_d), .run_d(run_d)
  );

  tmr_outsel #(.CW(CW)) u_out (
    .clk(clk), .rst(rst), .mode_d(mode_d), .valid_d(valid_d), .n_d(n_d),
    .el_d(el_d), .dn_d(dn_d), .ph_d(ph_d), .ph2_d(ph2_d), .run_d(run_d),
    .out_wave(out_wave), .count_val(count_val)
  );

  assign cfg_mode   = mode_q;
  assign cfg_bcd    = bcd_q;
  assign mode_valid = valid_q;

endmodule

// File: rtl/tmr_channel_chk.sv
module tmr_channel_chk #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          tick_en,
  input logic          gate_in,
  input logic          load_stb,
  input logic [2:0]    load_mode,
  input logic [CW-1:0] load_count,
  input logic          out_wave,
  input logic [CW-1:0] count_val,
  input logic [2:0]    cfg_mode,
  input logic          mode_valid
);

  logic g_prev;
  always_ff @(posedge clk) begin
    if (rst) g_prev <= 1'b0;
    else     g_prev <= gate_in;
  end

  // R1
  reset_idle_chk: assert property (@(posedge clk)
    rst |=> (!mode_valid && !out_wave && count_val == '0));

  // R2
  load_count_chk: assert property (@(posedge clk) disable iff (rst)
    load_stb |=> (count_val == $past(load_count)));

  // R3
  fold_mode_chk: assert property (@(posedge clk) disable iff (rst)
    (load_stb && load_mode[2] && load_mode[1]) |=> (cfg_mode == {1'b0, $past(load_mode[1:0])}));

  // R4
  gate_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_valid && cfg_mode == 3'd0 && !gate_in && !load_stb) |=> $stable(count_val));

  // R5
  term_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_valid && cfg_mode == 3'd0 && out_wave && !load_stb) |=> out_wave);

  // R6
  oneshot_done_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_valid && cfg_mode == 3'd1 && !out_wave && !load_stb && !(gate_in && !g_prev))
      |=> !out_wave);

  // R9
  strobe_once_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_valid && (cfg_mode == 3'd4 || cfg_mode == 3'd5) && out_wave &&
     tick_en && gate_in && !load_stb) |=> !out_wave);

endmodule

bind tmr_channel tmr_channel_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst(rst), .tick_en(tick_en), .gate_in(gate_in),
  .load_stb(load_stb), .load_mode(load_mode), .load_count(load_count),
  .out_wave(out_wave), .count_val(count_val), .cfg_mode(cfg_mode),
  .mode_valid(mode_valid)
);

// File: tb/tb_tmr_channel.sv
module tb_tmr_channel;

  localparam int CW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          tick = 1'b0, gate = 1'b0, ld = 1'b0, lbcd = 1'b0;
  logic [2:0]    lmode = '0;
  logic [CW-1:0] lcnt = '0;
  logic          out_wave, cfg_bcd, mode_valid;
  logic [CW-1:0] count_val;
  logic [2:0]    cfg_mode;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  tmr_channel #(.CW(CW)) dut (
    .clk(clk), .rst(rst), .tick_en(tick), .gate_in(gate), .load_stb(ld),
    .load_mode(lmode), .load_bcd(lbcd), .load_count(lcnt),
    .out_wave(out_wave), .count_val(count_val), .cfg_mode(cfg_mode),
    .cfg_bcd(cfg_bcd), .mode_valid(mode_valid)
  );

  // behavioural reference: elapsed ticks since load/restart
  bit     m_valid, m_gprev, m_rise;
  int     m_mode;
  longint m_n, m_d;

  always @(posedge clk) begin
    if (rst) begin
      m_valid = 0; m_mode = 0; m_n = 0; m_d = 0; m_gprev = 0;
    end else begin
      m_rise  = gate && !m_gprev;
      m_gprev = gate;
      if (ld) begin
        m_valid = 1;
        m_mode  = (lmode > 5) ? int'(lmode) - 4 : int'(lmode);
        m_n     = (lcnt == 0) ? 65536 : longint'(lcnt);
        m_d     = 0;
      end else if (m_valid) begin
        if (m_mode inside {1, 2, 3, 5} && m_rise) m_d = 0;
        else if (tick && (!(m_mode inside {0, 4}) || gate)) m_d = m_d + 1;
      end
    end
  end

  function automatic longint exp_out();
    if (!m_valid) return 0;
    case (m_mode)
      0: return longint'(m_d >= m_n);
      1: return longint'(m_d < m_n);
      2: return longint'((m_d % m_n == 0) && (m_d != 0));
      3: return longint'((m_d % m_n) < ((m_n + 1) / 2));
      default: return longint'(m_d == m_n);
    endcase
  endfunction

  function automatic longint exp_cnt();
    if (!m_valid) return 0;
    case (m_mode)
      2: return (m_n - (m_d % m_n)) & 64'hffff;
      3: return (m_n - ((2 * m_d) % m_n)) & 64'hffff;
      default: return (m_n - m_d) & 64'hffff;
    endcase
  endfunction

  function automatic string out_tag();
    if (!m_valid) return "R1";
    case (m_mode)
      0: return "R5";
      1: return "R6";
      2: return "R7";
      3: return "R8";
      default: return "R9";
    endcase
  endfunction

  function automatic string cnt_tag();
    if (!m_valid) return "R1";
    case (m_mode)
      2: return "R7";
      3: return "R8";
      default: return "R10";
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // compare at the falling edge, then drive the next inputs
  task automatic cyc(input bit t, input bit g, input bit l = 0,
                     input logic [2:0] md = 0, input logic [CW-1:0] c = 0,
                     input bit b = 0);
    @(negedge clk);
    if (!rst) begin
      chk(out_tag(), 32'(out_wave), 32'(exp_out()));
      chk(cnt_tag(), 32'(count_val), 32'(exp_cnt()));
    end
    tick = t; gate = g; ld = l; lmode = md; lcnt = c; lbcd = b;
  endtask

  task automatic run(input int n, input bit g);
    for (int i = 0; i < n; i++) cyc(1'b1, g);
  endtask

  logic [CW-1:0] hold_c;

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    cyc(1, 1);
    // R1: idle after reset, ticks ignored before a load
    chk("R1", 32'(mode_valid), 0);
    chk("R1", 32'(out_wave), 0);
    run(5, 1);
    chk("R1", 32'(count_val), 0);

    // mode 0, N=10, pause with gate low (R4, R5)
    cyc(1, 1, 1, 3'd0, 16'd10);
    run(4, 1);
    cyc(1, 0);
    hold_c = count_val;
    repeat (4) cyc(1, 0);
    chk("R4", 32'(count_val), 32'(hold_c));
    run(12, 1);

    // mode 1 one-shot with retrigger (R6, R4)
    cyc(0, 0, 1, 3'd1, 16'd6);
    run(10, 0);
    cyc(0, 1);
    run(10, 1);

    // mode 2, N=4 then N=1 (R7)
    cyc(0, 1, 1, 3'd2, 16'd4);
    run(20, 1);
    cyc(0, 1, 1, 3'd2, 16'd1);
    run(5, 1);

    // mode 3, odd and even N, retrigger (R8)
    cyc(0, 1, 1, 3'd3, 16'd5);
    run(20, 1);
    cyc(0, 1, 1, 3'd3, 16'd6);
    run(9, 1);
    cyc(1, 0);
    run(12, 1);

    // strobes (R9)
    cyc(0, 1, 1, 3'd4, 16'd3);
    run(3, 1); run(2, 0); run(6, 1);
    cyc(0, 0, 1, 3'd5, 16'd3);
    run(4, 0); cyc(1, 1); run(8, 1);

    // folding (R3)
    cyc(0, 1, 1, 3'd6, 16'd3);
    cyc(0, 1);
    chk("R3", 32'(cfg_mode), 2);
    run(8, 1);
    cyc(0, 1, 1, 3'd7, 16'd5);
    cyc(0, 1);
    chk("R3", 32'(cfg_mode), 3);
    run(10, 1);

    // zero load and wrap (R2, R10)
    cyc(1, 1, 1, 3'd0, 16'd0, 1'b1);
    cyc(0, 1);
    chk("R2", 32'(count_val), 0);
    chk("R2", 32'(cfg_bcd), 1);
    cyc(1, 1);
    cyc(0, 1);
    chk("R10", 32'(count_val), 32'hffff);
    cyc(0, 1, 1, 3'd1, 16'd2);
    run(6, 1);

    // random traffic
    for (int i = 0; i < 4000; i++) begin
      if ($urandom % 50 == 0)
        cyc(($urandom % 4) != 0, ($urandom % 8) != 0, 1'b1,
            3'($urandom % 8), 16'($urandom % 12), 1'($urandom % 2));
      else
        cyc(($urandom % 4) != 0, ($urandom % 8) != 0);
    end
    cyc(0, 1);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #600000;
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule